// File: doc/BRIEF.md
# NAND Factory Bad-Block Scanner

This block runs once after power-up, before any erase reaches the flash. It walks every block of a NAND array from the lowest block address to the highest. For each block it reads the factory marker locations in the spare area through a simple read request and response port. A block whose markers all read as erased is good. Any other value marks the block as bad, and the result goes into a one-bit-per-block map held inside the block.

A two-bit class code and a bus-width bit select where the marker sits. The four classes are SLC small page, SLC large page, SLC very large page and MLC. Depending on these settings the marker is one spare byte, two spare bytes or the first spare word. It is on the first page of the block for SLC classes and on the last page for MLC. The spare column starts right after the main page area: 512, 2048 or 4096 bytes. On a 16-bit bus this offset counts in words.

A count of bad blocks is kept, so firmware can compare it against its reserve budget. Firmware reads the map through a combinational lookup port. The port only ever issues reads, so the markers cannot be destroyed by the scan.

Top module: `nand_bbscan`

## Requirements
- R1: After reset, rd_req, busy and done are low and bad_count is zero.
- R2: A start pulse while idle or done begins a scan at block 0. The scan issues the marker reads of one block in marker order, then holds rd_req low for exactly one cycle while the verdict is written. It then moves to the next block. After the highest block, done goes high one cycle after that write cycle.
- R3: Class 0 (SLC small page) reads a single location on page 0. On an 8-bit bus this is byte column 517. On a 16-bit bus it is word column 256.
- R4: Class 1 (SLC large page) reads from page 0. On an 8-bit bus it reads byte columns 2048 then 2053. On a 16-bit bus it reads only word column 1024.
- R5: Class 2 (SLC very large page) always reads byte columns 4096 then 4101 on page 0, whatever the bus-width bit says.
- R6: Class 3 (MLC) reads one location on the last page of the block (all page bits set). This is byte column 2048 on an 8-bit bus or word column 1024 on a 16-bit bus.
- R7: On a byte read, only rsp_data[7:0] is compared against FFh and the upper byte has no effect. On a word read, all of rsp_data must equal FFFFh.
- R8: A block is recorded as bad (map_bad = 1 at its map_addr) when any of its marker reads is not erased. Otherwise it is recorded as good.
- R9: bad_count equals the number of blocks recorded as bad in the current scan. It is cleared when a scan starts.
- R10: busy is high from the cycle after an accepted start until done rises. busy and done are never high together. A start pulse while busy has no effect on the read sequence.
- R11: Once raised, rd_req and its block, page and column stay unchanged until the cycle in which rsp_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a scan |
| cfg_class | input | 2 | Device class: 0 SLC small, 1 SLC large, 2 SLC very large, 3 MLC |
| cfg_x16 | input | 1 | 1 selects a 16-bit data bus |
| rd_req | output | 1 | Read request, held until answered |
| rd_blk | output | BLK_W | Block address of the request |
| rd_page | output | PAGE_W | Page address within the block |
| rd_col | output | COL_W | Column (byte or word) of the request |
| rsp_valid | input | 1 | One-cycle response strobe for the standing request |
| rsp_data | input | 16 | Data returned with rsp_valid |
| map_addr | input | BLK_W | Block whose map bit is looked up |
| map_bad | output | 1 | Map bit of map_addr (1 = bad) |
| bad_count | output | BLK_W+1 | Bad blocks found in the current scan |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan complete; held until the next start |

## Verification
The assertions assume three things about the inputs. First, rsp_valid is a single-cycle pulse that arrives only while rd_req is high. Second, cfg_class and cfg_x16 hold still for the whole scan. Third, reads of the map do not race a running scan. The bench's responder honours all three. It answers only a standing request, after a varying latency of zero to three cycles, and drops rsp_valid on the next cycle. The configuration changes only between scans, and the map is read only after done. The one deliberate violation is a start pulse inside a scan, because the design must ignore it.

// File: rtl/nand_bbscan_pkg.sv
package nand_bbscan_pkg;

  typedef enum logic [1:0] {
    DEV_SLC_SMALL  = 2'd0,
    DEV_SLC_LARGE  = 2'd1,
    DEV_SLC_XLARGE = 2'd2,
    DEV_MLC        = 2'd3
  } dev_class_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_COMMIT = 2'd2,
    ST_DONE   = 2'd3
  } scan_state_e;

  // Main-area size in bytes for each class
  function automatic int unsigned main_bytes(dev_class_e c);
    case (c)
      DEV_SLC_SMALL:  return 512;
      DEV_SLC_XLARGE: return 4096;
      default:        return 2048;
    endcase
  endfunction

  // Word-wide access applies to every class except the very large page
  function automatic logic word_access(dev_class_e c, logic x16);
    return x16 && (c != DEV_SLC_XLARGE);
  endfunction

  // Number of marker reads per block (1 or 2)
  function automatic logic [1:0] marker_reads(dev_class_e c, logic x16);
    if (c == DEV_SLC_XLARGE) return 2'd2;
    if (c == DEV_SLC_LARGE && !x16) return 2'd2;
    return 2'd1;
  endfunction

  // Spare column of marker number idx
  function automatic int unsigned marker_col(dev_class_e c, logic x16, logic idx);
    int unsigned base;
    base = word_access(c, x16) ? main_bytes(c) / 2 : main_bytes(c);
    if (c == DEV_SLC_SMALL && !x16) return base + 5;
    if (idx) return base + 5;
    return base;
  endfunction

  // Erased test on returned data
  function automatic logic marker_erased(logic [15:0] d, logic wide);
    return wide ? (d == 16'hFFFF) : (d[7:0] == 8'hFF);
  endfunction

endpackage

// File: rtl/bbscan_locate.sv
module bbscan_locate
  import nand_bbscan_pkg::*;
#(
  parameter int COL_W = 13
)(
  input  dev_class_e       cls,
  input  logic             x16,
  input  logic             idx,
  output logic [COL_W-1:0] col,
  output logic [1:0]       n_reads,
  output logic             wide
);
  always_comb begin
    col     = COL_W'(marker_col(cls, x16, idx));
    n_reads = marker_reads(cls, x16);
    wide    = word_access(cls, x16);
  end
endmodule

// File: rtl/bbscan_ctrl.sv
module bbscan_ctrl
  import nand_bbscan_pkg::*;
#(
  parameter int BLK_W  = 6,
  parameter int PAGE_W = 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_class,
  input  logic              cfg_x16,
  input  logic              rsp_valid,
  input  logic [15:0]       rsp_data,
  input  logic [1:0]        n_reads,
  input  logic              wide,
  output dev_class_e        cls_q,
  output logic              x16_q,
  output logic              idx,
  output logic              rd_req,
  output logic [BLK_W-1:0]  rd_blk,
  output logic [PAGE_W-1:0] rd_page,
  output logic              blk_commit,
  output logic              blk_bad,
  output logic              scan_clear,
  output logic              busy,
  output logic              done
);
  scan_state_e      st;
  logic [BLK_W-1:0] blk;
  logic             all_ok;
  logic             marker_hit;
  logic             last_marker;
  logic             hit_erased;

  assign marker_hit  = (st == ST_READ) && rsp_valid;
  assign last_marker = idx || (n_reads == 2'd1);
  assign hit_erased  = marker_erased(rsp_data, wide);
  assign scan_clear  = start && (st == ST_IDLE || st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      blk    <= '0;
      idx    <= 1'b0;
      all_ok <= 1'b1;
      cls_q  <= DEV_SLC_SMALL;
      x16_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            st     <= ST_READ;
            blk    <= '0;
            idx    <= 1'b0;
            all_ok <= 1'b1;
            cls_q  <= dev_class_e'(cfg_class);
            x16_q  <= cfg_x16;
          end
        end
        ST_READ: begin
          if (marker_hit) begin
            all_ok <= all_ok & hit_erased;
            if (last_marker) st <= ST_COMMIT;
            else             idx <= 1'b1;
          end
        end
        default: begin
          all_ok <= 1'b1;
          idx    <= 1'b0;
          if (blk == '1) st <= ST_DONE;
          else begin
            blk <= blk + 1'b1;
            st  <= ST_READ;
          end
        end
      endcase
    end
  end

  assign rd_req     = (st == ST_READ);
  assign rd_blk     = blk;
  assign rd_page    = (cls_q == DEV_MLC) ? '1 : '0;
  assign blk_commit = (st == ST_COMMIT);
  assign blk_bad    = ~all_ok;
  assign busy       = (st == ST_READ) || (st == ST_COMMIT);
  assign done       = (st == ST_DONE);
endmodule

// File: rtl/bbscan_map.sv
module bbscan_map #(
  parameter int BLK_W = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic             wr_bad,
  input  logic [BLK_W-1:0] rd_addr,
  output logic             rd_bad,
  output logic [BLK_W:0]   bad_count
);
  localparam int NBLK = 1 << BLK_W;

  logic [NBLK-1:0] bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits      <= '0;
      bad_count <= '0;
    end else begin
      if (clr)                  bad_count <= '0;
      else if (wr_en && wr_bad) bad_count <= bad_count + 1'b1;
      if (wr_en) bits[wr_blk] <= wr_bad;
    end
  end

  assign rd_bad = bits[rd_addr];
endmodule

// File: rtl/nand_bbscan.sv
module nand_bbscan
  import nand_bbscan_pkg::*;
#(
  parameter int BLK_W  = 6,
  parameter int PAGE_W = 6,
  parameter int COL_W  = 13
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_class,
  input  logic              cfg_x16,
  output logic              rd_req,
  output logic [BLK_W-1:0]  rd_blk,
  output logic [PAGE_W-1:0] rd_page,
  output logic [COL_W-1:0]  rd_col,
  input  logic              rsp_valid,
  input  logic [15:0]       rsp_data,
  input  logic [BLK_W-1:0]  map_addr,
  output logic              map_bad,
  output logic [BLK_W:0]    bad_count,
  output logic              busy,
  output logic              done
);
  dev_class_e cls_q;
  logic       x16_q;
  logic       idx;
  logic [1:0] n_reads;
  logic       wide;
  logic       blk_commit;
  logic       blk_bad;
  logic       scan_clear;

  bbscan_locate #(.COL_W(COL_W)) loc_i (
    .cls(cls_q), .x16(x16_q), .idx(idx),
    .col(rd_col), .n_reads(n_reads), .wide(wide)
  );

  bbscan_ctrl #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_class(cfg_class), .cfg_x16(cfg_x16),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .n_reads(n_reads), .wide(wide),
    .cls_q(cls_q), .x16_q(x16_q), .idx(idx),
    .rd_req(rd_req), .rd_blk(rd_blk), .rd_page(rd_page),
    .blk_commit(blk_commit), .blk_bad(blk_bad), .scan_clear(scan_clear),
    .busy(busy), .done(done)
  );

  bbscan_map #(.BLK_W(BLK_W)) map_i (
    .clk(clk), .rst_n(rst_n), .clr(scan_clear),
    .wr_en(blk_commit), .wr_blk(rd_blk), .wr_bad(blk_bad),
    .rd_addr(map_addr), .rd_bad(map_bad), .bad_count(bad_count)
  );
endmodule

// File: rtl/nand_bbscan_chk.sv
module nand_bbscan_chk #(
  parameter int BLK_W  = 6,
  parameter int PAGE_W = 6,
  parameter int COL_W  = 13
)(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        cfg_class,
  input logic              rsp_valid,
  input logic              rd_req,
  input logic [BLK_W-1:0]  rd_blk,
  input logic [PAGE_W-1:0] rd_page,
  input logic [COL_W-1:0]  rd_col,
  input logic              busy,
  input logic              done,
  input logic [BLK_W:0]    bad_count,
  input logic              blk_commit
);
  a_r11_hold_until_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rsp_valid) |=> (rd_req && $stable(rd_blk) && $stable(rd_page) && $stable(rd_col)));

  a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r10_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);

  a_r9_count_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_commit && !(start && !busy)) |=> $stable(bad_count));

  a_r2_same_block_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req)) |-> (rd_blk == $past(rd_blk)));

  a_r2_commit_gap: assert property (@(posedge clk) disable iff (!rst_n)
    blk_commit |-> !rd_req);

  a_r6_mlc_last_page: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cfg_class == 2'd3) |-> (&rd_page));
endmodule

bind nand_bbscan nand_bbscan_chk #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_class(cfg_class),
  .rsp_valid(rsp_valid), .rd_req(rd_req), .rd_blk(rd_blk), .rd_page(rd_page),
  .rd_col(rd_col), .busy(busy), .done(done), .bad_count(bad_count),
  .blk_commit(blk_commit)
);

// File: tb/nand_bbscan_tb_top.sv
module nand_bbscan_tb_top;
  localparam int BLK_W  = 6;
  localparam int PAGE_W = 6;
  localparam int COL_W  = 13;
  localparam int NBLK   = 1 << BLK_W;
  localparam int NPAGE  = 1 << PAGE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        cfg_class = 2'd0;
  logic              cfg_x16 = 1'b0;
  logic              rd_req;
  logic [BLK_W-1:0]  rd_blk;
  logic [PAGE_W-1:0] rd_page;
  logic [COL_W-1:0]  rd_col;
  logic              rsp_valid = 1'b0;
  logic [15:0]       rsp_data = 16'h0;
  logic [BLK_W-1:0]  map_addr = '0;
  logic              map_bad;
  logic [BLK_W:0]    bad_count;
  logic              busy;
  logic              done;

  always #2.5 clk = ~clk;

  nand_bbscan #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .COL_W(COL_W)) dut_i (.*);

  typedef struct { int blk; int page; int col; int idx; int nrd; } rd_t;
  rd_t q[$];
  bit  exp_bad[NBLK];
  int  checks = 0;
  int  errors = 0;
  int  total_cycles = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference marker columns, restated per requirement
  function automatic void ref_cols(int cls, bit x16, output int c0, output int c1, output int n);
    n = 1; c1 = 0;
    case (cls)
      0: c0 = x16 ? 256 : 517;                                  // R3
      1: if (x16) c0 = 1024; else begin c0 = 2048; c1 = 2053; n = 2; end  // R4
      2: begin c0 = 4096; c1 = 4101; n = 2; end                 // R5
      default: c0 = x16 ? 1024 : 2048;                          // R6
    endcase
  endfunction

  task automatic run_scan(int cls, bit x16, bit all_good, bit inject, int seed);
    int c0, c1, n, kind, mdl_count, phase, wait_cnt, cyc, inj_at;
    bit wide, bad_here, finished;
    rd_t e;
    string tag;
    tag = (cls == 0) ? "R3" : (cls == 1) ? "R4" : (cls == 2) ? "R5" : "R6";
    ref_cols(cls, x16, c0, c1, n);
    wide = x16 && (cls != 2);
    q.delete();
    mdl_count = 0;
    for (int b = 0; b < NBLK; b++) begin
      for (int i = 0; i < n; i++) begin
        e.blk = b; e.page = (cls == 3) ? NPAGE - 1 : 0;
        e.col = (i == 0) ? c0 : c1; e.idx = i; e.nrd = n;
        q.push_back(e);
      end
      kind = (b * 3 + cls + int'(x16)) % 4;
      exp_bad[b] = !all_good && (kind < 2);
      if (exp_bad[b]) mdl_count++;
    end
    cfg_class = 2'(cls); cfg_x16 = x16;
    start = 1'b1;
    @(negedge clk); total_cycles++;
    start = 1'b0;
    phase = 0; wait_cnt = seed % 4; cyc = 0; finished = 0;
    inj_at = 9;
    forever begin
      if (rsp_valid) begin
        rsp_valid = 1'b0;
        e = q.pop_front();
        if (q.size() == 0 || q[0].blk != e.blk) phase = 1;
      end
      if (inject) start = (cyc == inj_at);  // R10: ignored while busy
      if (phase == 1) begin
        chk(rd_req == 1'b0, "R2 commit gap", int'(rd_req), 0);
        chk(done == 1'b0, "R2 done early", int'(done), 0);
        chk(busy == 1'b1, "R10 busy in commit", int'(busy), 1);
        phase = 2;
      end else if (phase == 2) begin
        chk(done == (q.size() == 0), "R2 done after last", int'(done), int'(q.size() == 0));
        chk(rd_req == (q.size() != 0), "R2 next block req", int'(rd_req), int'(q.size() != 0));
        chk(busy == (q.size() != 0), "R10 busy level", int'(busy), int'(q.size() != 0));
        phase = 0;
        if (q.size() == 0) finished = 1;
      end else begin
        chk(rd_req == 1'b1, "R11 req held", int'(rd_req), 1);
        chk(busy == 1'b1 && done == 1'b0, "R10 busy while reading", int'(busy), 1);
        if (q.size() > 0) begin
          chk(int'(rd_blk) == q[0].blk, "R2 block order", int'(rd_blk), q[0].blk);
          chk(int'(rd_page) == q[0].page, {tag, " page"}, int'(rd_page), q[0].page);
          chk(int'(rd_col) == q[0].col, {tag, " column"}, int'(rd_col), q[0].col);
        end
      end
      if (finished) break;
      if (rd_req && q.size() > 0 && phase == 0) begin
        if (wait_cnt == 0) begin
          e = q[0];
          kind = (e.blk * 3 + cls + int'(x16)) % 4;
          bad_here = !all_good && ((kind == 0 && e.idx == 0) || (kind == 1 && e.idx == e.nrd - 1));
          if (wide) rsp_data = bad_here ? ((e.blk % 2 == 1) ? 16'hFF7F : 16'h7FFF) : 16'hFFFF;  // R7
          else      rsp_data = bad_here ? {8'hFF, (e.blk % 2 == 1) ? 8'hFE : 8'h00}
                                        : {8'(e.blk * 37 + e.idx * 11 + seed), 8'hFF};      // R7
          rsp_valid = 1'b1;
          wait_cnt = (e.blk + e.idx * 2 + seed) % 4;
        end else wait_cnt--;
      end
      @(negedge clk); cyc++; total_cycles++;
      if (cyc > 20000 || total_cycles > 190000) begin
        chk(1'b0, "watchdog", cyc, 0);
        break;
      end
    end
    start = 1'b0;
    chk(int'(bad_count) == mdl_count, "R9 bad count", int'(bad_count), mdl_count);
    for (int b = 0; b < NBLK; b++) begin
      map_addr = BLK_W'(b);
      #1;
      chk(map_bad == exp_bad[b], "R8 map bit", int'(map_bad), int'(exp_bad[b]));
    end
    @(negedge clk); total_cycles++;
    chk(done == 1'b1 && busy == 1'b0, "R10 done held", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_req == 1'b0, "R1 rd_req", int'(rd_req), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(bad_count == '0, "R1 bad_count", int'(bad_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_req == 1'b0 && busy == 1'b0, "R1 idle after reset", int'(busy), 0);
    for (int s = 0; s < 8; s++) begin
      run_scan(s / 2, s[0], 1'b0, s == 1, s);
    end
    run_scan(1, 1'b0, 1'b1, 1'b0, 5);   // all good: R9 count cleared on restart
    run_scan(2, 1'b1, 1'b0, 1'b1, 2);   // R5 ignores x16 bit
    run_scan(3, 1'b0, 1'b0, 1'b0, 7);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule